// File: doc/BRIEF.md
# SPI Frame Chip-Select Generator

This block sits beside an SPI master and drives the slave-select line on its own, so the master never has to touch the select between frames. It samples the serial clock into the system clock domain, picks out one kind of serial clock edge according to the SPI mode, and counts those edges. When the count covers a programmed frame length, the select line flips and the count starts again from zero. On the next system clock cycle the line is flipped back. While the line was active before the frame ended, every frame therefore ends with an inactive gap exactly one system clock wide.

Software keeps two controls. A force strobe loads the select to a chosen level without touching the edge count. A write-one clear removes the frame-done flag, which otherwise stays set once a frame completes. A run input holds the counter at zero while it is low. The expected use is: hold run low, load the frame length and mode, raise run, force the select active, then let the block frame the traffic.

Top module: `frame_select_gen`

## Requirements
- R1: After reset the select is inactive (chip_sel high with the default active-low polarity), evt_flag is 0 and the edge count is 0.
- R2: With spi_mode 0 or 3 only rising edges of sclk are counted; with spi_mode 1 or 2 only falling edges are counted.
- R3: When a counted edge brings the count to frame_len, the internal select level toggles, evt_flag is set and the count restarts from zero, so the next frame is again frame_len edges long.
- R4: In the system clock cycle after a frame ends, the select toggles back unless a force strobe arrives; an active select is therefore inactive for exactly one system clock cycle per frame.
- R5: A frame_len of 0 stands for the largest frame, 2^CNT_W counted edges.
- R6: evt_flag stays set until evt_clr is 1; evt_clr at 0 has no effect; a frame end in the same cycle as evt_clr leaves the flag set.
- R7: A force_we pulse loads the select with force_level (1 = active) on the next clock and has priority over a frame end; it does not change the edge count or the frame timing.
- R8: While run is 0 the count is held at zero and sclk edges are not counted; counting of a full frame begins when run goes to 1.
- R9: Parameter ACTIVE_HIGH sets the polarity of chip_sel: 0 (default) drives low for active, 1 drives high for active.
- R10: The sclk input passes a two-stage synchronizer, so a counted sclk edge changes chip_sel on the third rising clk edge after the sclk transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk | input | 1 | SPI serial clock, asynchronous to clk |
| frame_len | input | CNT_W | Counted edges per frame, 0 means 2^CNT_W |
| spi_mode | input | 2 | SPI mode 0..3, selects the counted edge |
| run | input | 1 | 1 lets the counter run, 0 holds it at zero |
| force_we | input | 1 | One-cycle strobe that loads the select level |
| force_level | input | 1 | Level loaded by force_we, 1 = active |
| evt_clr | input | 1 | Write-one clear of evt_flag |
| chip_sel | output | 1 | Slave-select line, polarity set by ACTIVE_HIGH |
| evt_flag | output | 1 | Frame-done flag, sticky until cleared |

## Verification
The bench sweeps every frame length, including 0, in every SPI mode, and checks after the leading and the trailing half of the final sclk period whether the frame has ended; a design that counted the wrong edge would end the frame half a period early or late, and one that mapped length 0 to a single edge would end frames on every edge. It counts how many clock samples the select spends inactive per frame, so a missing restore shows up as a select stuck inactive and a double toggle as a gap of zero or two cycles. Back-to-back frames catch a counter that does not restart at zero, and forcing the select in mid-frame or toggling sclk with run low catches a counter that is disturbed by either.

// File: rtl/fsg_pkg.sv
// Package: fsg_pkg
// Shared helpers for the frame chip-select generator.
// Assumes SPI mode numbering 0..3 on a two-bit field.
package fsg_pkg;

    // SPI mode as carried on the spi_mode port.
    typedef logic [1:0] spi_mode_t;

    // Synchronized sclk sample and its value one clock earlier.
    typedef struct packed {
        logic now;
        logic prev;
    } sclk_view_t;

    // Modes 0 and 3 count rising edges, modes 1 and 2 falling edges.
    function automatic logic counts_rising(input spi_mode_t mode);
        return (mode == 2'd0) || (mode == 2'd3);
    endfunction

    // Last count value of a frame; length 0 wraps to the all-ones value.
    function automatic logic [31:0] last_count(input logic [31:0] len, input int width);
        logic [31:0] mask;
        mask = (width >= 32) ? 32'hFFFF_FFFF : ((32'd1 << width) - 32'd1);
        return (len - 32'd1) & mask;
    endfunction

endpackage

// File: rtl/fsg_edge_sync.sv
// Module: fsg_edge_sync
// Brings sclk into the clk domain through SYNC_STAGES flops and emits a
// one-cycle step pulse on the edge kind that spi_mode selects.
// Assumes sclk stays at each level for at least two clk periods.
module fsg_edge_sync
    import fsg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sclk,
    input  spi_mode_t  spi_mode,
    output sclk_view_t view,
    output logic       step
);
    logic [SYNC_STAGES-1:0] chain;
    logic                   prev_q;
    logic                   rise;
    logic                   fall;

    // Synchronizer stages: stage 0 samples the pin, each next stage the one before.
    genvar g;
    generate
        for (g = 0; g < SYNC_STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[0] <= 1'b0;
                    else        chain[0] <= sclk;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[g] <= 1'b0;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    // Delay the synchronized level by one clock for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= chain[SYNC_STAGES-1];
    end

    // Pick the counted edge for the current mode.
    always_comb begin
        view.now  = chain[SYNC_STAGES-1];
        view.prev = prev_q;
        rise      = view.now & ~view.prev;
        fall      = ~view.now & view.prev;
        step      = counts_rising(spi_mode) ? rise : fall;
    end

endmodule

// File: rtl/fsg_frame_counter.sv
// Module: fsg_frame_counter
// Counts step pulses while run is high and reports the step that
// completes a frame; the count then restarts at zero.
// Assumes frame_len may change only while run is low.
module fsg_frame_counter
    import fsg_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             step,
    input  logic [CNT_W-1:0] frame_len,
    output logic [CNT_W-1:0] cnt,
    output logic             frame_end
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] term;

    // Last count of a frame; a zero length wraps to all ones (full range).
    always_comb begin
        term      = frame_len - ONE;
        frame_end = run && step && (cnt == term);
    end

    // Edge counter: held at zero when stopped, cleared at frame end.
    always_ff @(posedge clk) begin
        if (!rst_n)         cnt <= '0;
        else if (!run)      cnt <= '0;
        else if (frame_end) cnt <= '0;
        else if (step)      cnt <= cnt + ONE;
    end

endmodule

// File: rtl/fsg_select_ctrl.sv
// Module: fsg_select_ctrl
// Holds the logical select level (1 = active) and the frame-done flag.
// A frame end toggles the level and a one-shot restore toggles it back
// on the next clock; a force strobe overrides both.
module fsg_select_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_end,
    input  logic force_we,
    input  logic force_level,
    input  logic evt_clr,
    output logic sel_level,
    output logic evt_flag
);
    logic restore_q;

    // Arm the one-shot restore for the cycle after an unforced frame end.
    always_ff @(posedge clk) begin
        if (!rst_n) restore_q <= 1'b0;
        else        restore_q <= frame_end && !force_we;
    end

    // Select level: force first, then frame-end toggle, then restore toggle.
    always_ff @(posedge clk) begin
        if (!rst_n)         sel_level <= 1'b0;
        else if (force_we)  sel_level <= force_level;
        else if (frame_end) sel_level <= ~sel_level;
        else if (restore_q) sel_level <= ~sel_level;
    end

    // Sticky flag: a new frame end beats a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)         evt_flag <= 1'b0;
        else if (frame_end) evt_flag <= 1'b1;
        else if (evt_clr)   evt_flag <= 1'b0;
    end

endmodule

// File: rtl/frame_select_gen.sv
// Module: frame_select_gen
// Top of the frame chip-select generator: synchronizes sclk, counts the
// mode-selected edges and drives chip_sel with a one-cycle inactive gap
// at the end of each frame.
// Assumes run is low while frame_len or spi_mode change and while sclk
// moves to its idle level.
module frame_select_gen
    import fsg_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter bit ACTIVE_HIGH = 1'b0,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sclk,
    input  logic [CNT_W-1:0] frame_len,
    input  logic [1:0]       spi_mode,
    input  logic             run,
    input  logic             force_we,
    input  logic             force_level,
    input  logic             evt_clr,
    output logic             chip_sel,
    output logic             evt_flag
);
    sclk_view_t       view;
    logic             step;
    logic [CNT_W-1:0] cnt;
    logic             frame_end;
    logic             sel_level;

    fsg_edge_sync #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk     (sclk),
        .spi_mode (spi_mode),
        .view     (view),
        .step     (step)
    );

    fsg_frame_counter #(
        .CNT_W(CNT_W)
    ) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .step      (step),
        .frame_len (frame_len),
        .cnt       (cnt),
        .frame_end (frame_end)
    );

    fsg_select_ctrl u_sel (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_end   (frame_end),
        .force_we    (force_we),
        .force_level (force_level),
        .evt_clr     (evt_clr),
        .sel_level   (sel_level),
        .evt_flag    (evt_flag)
    );

    // Output polarity chosen at build time.
    generate
        if (ACTIVE_HIGH) begin : g_pol_high
            assign chip_sel = sel_level;
        end else begin : g_pol_low
            assign chip_sel = ~sel_level;
        end
    endgenerate

endmodule

// File: rtl/fsg_checker.sv
// Module: fsg_checker
// Temporal checks on the frame chip-select generator, bound to its top.
module fsg_checker #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       spi_mode,
    input logic             run,
    input logic             force_we,
    input logic             force_level,
    input logic             evt_clr,
    input logic             step,
    input logic             view_now,
    input logic             view_prev,
    input logic             frame_end,
    input logic [CNT_W-1:0] cnt,
    input logic             sel_level,
    input logic             evt_flag
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    // R2: a counted step needs a change of the synchronized sclk.
    assert_step_on_change_R2: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> (view_now != view_prev));

    // R2: the change direction matches the mode.
    assert_step_direction_R2: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> (view_now == ((spi_mode == 2'd0) || (spi_mode == 2'd3))));

    // R3: a frame end restarts the count.
    assert_wrap_to_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> (cnt == '0));

    // R3: an ordinary step advances the count by one.
    assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && step && !frame_end) |=> (cnt == $past(cnt) + ONE));

    // R3: an unforced frame end flips the select level.
    assert_toggle_on_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end && !force_we) |=> (sel_level != $past(sel_level)));

    // R4: one cycle later the level is back where it was before the frame end.
    assert_restore_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(frame_end) && !$past(force_we) && !force_we && !frame_end)
            |=> (sel_level == $past(sel_level, 2)));

    // R6: a frame end sets the flag.
    assert_flag_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> evt_flag);

    // R6: a clear without a frame end removes it.
    assert_flag_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_clr && !frame_end) |=> !evt_flag);

    // R6: without a clear the flag does not fall.
    assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_flag && !evt_clr) |=> evt_flag);

    // R7: a force strobe loads the requested level.
    assert_force_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        force_we |=> (sel_level == $past(force_level)));

    // R8: the count is zero after a stopped cycle.
    assert_hold_when_stopped_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt == '0));

endmodule

bind frame_select_gen fsg_checker #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .spi_mode    (spi_mode),
    .run         (run),
    .force_we    (force_we),
    .force_level (force_level),
    .evt_clr     (evt_clr),
    .step        (step),
    .view_now    (view.now),
    .view_prev   (view.prev),
    .frame_end   (frame_end),
    .cnt         (cnt),
    .sel_level   (sel_level),
    .evt_flag    (evt_flag)
);

// File: tb/frame_select_gen_test.sv
// Bench for frame_select_gen: sweeps all modes and frame lengths of a
// 4-bit configuration and checks frame ends from the ports.
module frame_select_gen_test;
    localparam int  W        = 4;
    localparam int  HALF     = 4;      // clk cycles per sclk half period
    localparam int  WATCHDOG = 150000;
    localparam logic ACT     = 1'b0;   // default polarity: low is active (R9)

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sclk = 1'b0;
    logic [W-1:0] frame_len = '0;
    logic [1:0]   spi_mode = 2'd0;
    logic         run = 1'b0;
    logic         force_we = 1'b0;
    logic         force_level = 1'b0;
    logic         evt_clr = 1'b0;
    logic         chip_sel;
    logic         evt_flag;

    int checks = 0;
    int fails  = 0;
    int inact  = 0;
    int cycles = 0;
    bit done   = 1'b0;

    frame_select_gen #(.CNT_W(W)) uut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .frame_len(frame_len),
        .spi_mode(spi_mode), .run(run), .force_we(force_we),
        .force_level(force_level), .evt_clr(evt_clr),
        .chip_sel(chip_sel), .evt_flag(evt_flag)
    );

    always #10 clk = ~clk;  // 50 MHz

    // Watchdog: a hung run counts as one failure and still prints the summary.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == WATCHDOG && !done) begin
            fails  = fails + 1;
            checks = checks + 1;
            $display("FAIL watchdog: actual %0d cycles expected < %0d", cycles, WATCHDOG);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One clk cycle, sampled at the falling edge; counts inactive samples.
    task automatic tick();
        @(negedge clk);
        if (chip_sel !== ACT) inact = inact + 1;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    // Move sclk and wait out the synchronizer plus restore (R10 latency 3).
    task automatic half_period(input logic lvl);
        sclk = lvl;
        ticks(HALF);
    endtask

    task automatic pulse_force(input logic lvl);
        force_level = lvl;
        force_we = 1'b1;
        @(negedge clk);
        force_we = 1'b0;
    endtask

    task automatic pulse_clear();
        evt_clr = 1'b1;
        @(negedge clk);
        evt_clr = 1'b0;
    endtask

    // Stop, reconfigure with sclk at idle, restart with select active and flag clear.
    task automatic setup(input int mode, input int len);
        run = 1'b0;
        @(negedge clk);
        spi_mode  = mode[1:0];
        frame_len = len[W-1:0];
        sclk      = (mode >= 2);
        ticks(6);
        run = 1'b1;
        ticks(2);
        pulse_force(1'b1);
        pulse_clear();
        ticks(2);
        inact = 0;
    endtask

    initial begin
        int  lim;
        bit  lead;
        logic idle;

        // R1: reset state.
        ticks(3);
        check(chip_sel === ~ACT, "R1 reset select inactive (R9 active-low)", chip_sel, ~ACT);
        check(evt_flag === 1'b0, "R1 reset flag", evt_flag, 0);
        rst_n = 1'b1;
        ticks(3);
        check(chip_sel === ~ACT && evt_flag === 1'b0, "R1 after release",
              {chip_sel, evt_flag}, {~ACT, 1'b0});

        // Exhaustive sweep: every mode and every frame length (R2, R3, R4, R5, R10).
        for (int m = 0; m < 4; m++) begin
            for (int len = 0; len < (1 << W); len++) begin
                setup(m, len);
                lim  = (len == 0) ? (1 << W) : len;
                lead = (m == 0) || (m == 2);
                idle = (m >= 2);
                for (int f = 0; f < 2; f++) begin
                    inact = 0;
                    for (int c = 0; c < lim; c++) begin
                        half_period(~idle);
                        if (c == lim - 1)
                            check(inact == (lead ? 1 : 0),
                                  (len == 0) ? "R5 full-range frame leading half" :
                                               "R2 edge choice at leading half",
                                  inact, lead ? 1 : 0);
                        half_period(idle);
                        if (c == lim - 2)
                            check(evt_flag === 1'b0, "R3 no early frame end", evt_flag, 0);
                    end
                    check(inact == 1, (len == 0) ? "R5 one gap per full-range frame" :
                                                   "R4 one inactive cycle per frame",
                          inact, 1);
                    check(chip_sel === ACT, "R4 select restored", chip_sel, ACT);
                    check(evt_flag === 1'b1, "R3 flag after frame", evt_flag, 1);
                    ticks(5);
                    check(evt_flag === 1'b1, "R6 flag sticky", evt_flag, 1);
                    pulse_clear();
                    tick();
                    check(evt_flag === 1'b0, "R6 flag cleared by one", evt_flag, 0);
                end
            end
        end

        // R10: exact latency, mode 0, length 1: gap sits on the 3rd clk after sclk rises.
        setup(0, 1);
        sclk = 1'b1;
        tick(); tick();
        check(chip_sel === ACT, "R10 no change before 3rd clock", chip_sel, ACT);
        tick();
        check(chip_sel === ~ACT, "R10 gap on 3rd clock", chip_sel, ~ACT);
        tick();
        check(chip_sel === ACT, "R10 restored on 4th clock", chip_sel, ACT);
        half_period(1'b1);
        half_period(1'b0);
        pulse_clear();

        // R6: clear written as zero does nothing.
        setup(1, 2);
        for (int c = 0; c < 2; c++) begin half_period(1'b1); half_period(1'b0); end
        evt_clr = 1'b0;
        ticks(4);
        check(evt_flag === 1'b1, "R6 zero write no effect", evt_flag, 1);

        // R7: force mid-frame does not shift the frame end.
        setup(0, 5);
        for (int c = 0; c < 2; c++) begin half_period(1'b1); half_period(1'b0); end
        pulse_force(1'b0);
        tick();
        check(chip_sel === ~ACT, "R7 forced inactive", chip_sel, ~ACT);
        pulse_force(1'b1);
        tick();
        check(chip_sel === ACT, "R7 forced active", chip_sel, ACT);
        inact = 0;
        for (int c = 0; c < 2; c++) begin half_period(1'b1); half_period(1'b0); end
        check(evt_flag === 1'b0 && inact == 0, "R7 no end after 4 edges", inact, 0);
        half_period(1'b1);
        half_period(1'b0);
        check(evt_flag === 1'b1 && inact == 1, "R7 end at 5th edge", inact, 1);

        // R8: edges with run low are ignored; a full frame follows the release.
        setup(0, 4);
        run = 1'b0;
        for (int c = 0; c < 3; c++) begin half_period(1'b1); half_period(1'b0); end
        check(evt_flag === 1'b0 && inact == 0, "R8 stopped counter ignores edges", inact, 0);
        run = 1'b1;
        ticks(2);
        for (int c = 0; c < 3; c++) begin half_period(1'b1); half_period(1'b0); end
        check(evt_flag === 1'b0, "R8 no end after 3 edges", evt_flag, 0);
        half_period(1'b1);
        half_period(1'b0);
        check(evt_flag === 1'b1 && inact == 1, "R8 end after 4 edges", inact, 1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule